// File: doc/BRIEF.md
# Synchronous Burst SRAM Access Controller

This block is a clocked, single-ported static memory with a shared 36-bit data path. The path carries four lanes of nine bits, and each lane is a data byte plus its parity bit. Every rising clock edge samples two address strobes, three chip selects, a global write enable, a byte write enable with four lane selects, a burst advance input and a burst order select. From these inputs the block starts, continues, suspends or ends single and four-beat burst accesses against an internal register array.

The two strobes act differently. The processor strobe is gated by the first chip select and always opens an access as a read. A write through it lands one edge later, as a continuation cycle. The controller strobe can write on the edge that samples it. Read data passes through an output register. The drive enable for the external bus drivers is held low after a deselect, during write traffic, while the output enable is high and while the block is asleep. A power-down input reaches the core through two flops, so entering and leaving sleep each take two edges. The array keeps its contents through sleep.

The bus is split into separate input, output and drive-enable signals so that a testbench can drive and observe it directly.

Top module: `sburst_sram`

## Requirements
- R1: An access begins only when `cs1_n`=0, `cs2`=1 and `cs3_n`=0. A strobe sampled while any of the three is inactive deselects the block: `drv_en` is 0 after that edge even if a read was in flight, and the burst in progress ends.
- R2: While `cs1_n`=1 the processor strobe `cpu_stb_n` has no effect. A burst in progress continues as if no strobe were present, and with no burst in progress nothing starts.
- R3: An edge that samples `cpu_stb_n`=0 with all selects active always performs a read, whatever the write inputs are. Write inputs take effect only at a later strobe-free edge, at the current burst address (`adv_n`=1) or the next one (`adv_n`=0).
- R4: An edge that samples `ctl_stb_n`=0 with `cpu_stb_n`=1, all selects active and an active write input writes `din` at `addr` on that same edge.
- R5: `gwe_n`=0 writes all four lanes, whatever `bwe_n` and `lane_sel_n` are.
- R6: With `gwe_n`=1 and `bwe_n`=0, only the lanes whose `lane_sel_n` bit is 0 are written, and the other lanes keep their contents. Lane i is bits 9i+8..9i, with parity in bit 9i+8. With `gwe_n`=1 and either `bwe_n`=1 or no lane selected, the cycle is a read.
- R7: A read whose address is sampled at edge k drives its word on `dout` with `drv_en`=1 after edge k+1, provided `oe_n`=0. Back-to-back reads return one word per cycle. The first cycle after an access starts from deselect is never driven.
- R8: `oe_n` acts without a clock: while it is 1, `drv_en` is 0, and when it returns to 0 the driven word comes back in the same cycle.
- R9: After any edge that performs a write, `drv_en` is 0 for the following cycle.
- R10: With `lin_mode`=0, each strobe-free cycle with `adv_n`=0 moves the two low address bits to start XOR step, where the step runs 1, 2, 3 and wraps. With `adv_n`=1 the current address is reused (suspend). The upper address bits never change within a burst.
- R11: With `lin_mode`=1 the two low address bits follow start plus step, modulo 4.
- R12: The block is asleep from the second edge after `pdown` rises until the second edge after it falls. While asleep no access occurs, `drv_en` is 0, any open burst is abandoned and the stored words are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of control state |
| addr | input | ADDR_W | Word address sampled with a strobe |
| cpu_stb_n | input | 1 | Processor address strobe, active low, gated by cs1_n |
| ctl_stb_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| cs1_n | input | 1 | Chip select 1, active low |
| cs2 | input | 1 | Chip select 2, active high |
| cs3_n | input | 1 | Chip select 3, active low |
| gwe_n | input | 1 | Global write enable, active low |
| bwe_n | input | 1 | Byte write enable, active low |
| lane_sel_n | input | LANES | Per-lane write selects, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| lin_mode | input | 1 | Burst order: 1 linear, 0 interleaved |
| pdown | input | 1 | Power-down (sleep) request |
| din | input | LANES*LANE_W | Write data |
| dout | output | LANES*LANE_W | Registered read data |
| drv_en | output | 1 | Enable for the external bus drivers |

## Verification
The bench builds the block with ADDR_W=6, which gives a 64-word array, and keeps the default of four 9-bit lanes. With only 64 words the bench can fill every address with a known pattern before the checks begin. The random phase then keeps hitting the same words, so byte merges, burst wraps across the low two bits and sleep retention are all checked against a complete shadow copy. The lane count and width are kept at their defaults because parity-per-lane placement is part of the checked field layout.

// File: rtl/sbs_pkg.sv
package sbs_pkg;

  typedef enum logic [1:0] {
    OP_IDLE,
    OP_READ,
    OP_WRITE,
    OP_DESEL
  } op_e;

  // Low two address bits for burst step k from start s.
  function automatic logic [1:0] burst_lo(input logic [1:0] s, input logic [1:0] k,
                                          input logic lin);
    return lin ? 2'(s + k) : (s ^ k);
  endfunction

endpackage

// File: rtl/sbs_sleep_sync.sv
module sbs_sleep_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic pdown,
  output logic asleep
);
  logic s1_q, s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= pdown;
      s2_q <= s1_q;
    end
  end

  assign asleep = s2_q;

  AST_SLEEP_ENTRY_LAT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(asleep) |-> $past(pdown, 2)); // R12
  AST_SLEEP_EXIT_LAT: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(asleep) |-> !$past(pdown, 2)); // R12
endmodule

// File: rtl/sbs_burst_ctr.sv
module sbs_burst_ctr
  import sbs_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          step,
  input  logic          adv,
  input  logic          lin,
  input  logic [AW-1:0] load_addr,
  output logic [AW-1:0] cont_addr
);
  logic [AW-3:0] base_q;
  logic [1:0]    start_q, k_q, k_nx;

  assign k_nx      = k_q + {1'b0, adv};
  assign cont_addr = {base_q, burst_lo(start_q, k_nx, lin)};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q  <= '0;
      start_q <= '0;
      k_q     <= '0;
    end else if (load) begin
      base_q  <= load_addr[AW-1:2];
      start_q <= load_addr[1:0];
      k_q     <= '0;
    end else if (step) begin
      k_q <= k_nx;
    end
  end

  AST_BURST_BASE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load) |=> $stable(base_q) && $stable(start_q)); // R10
  AST_BURST_SUSPEND: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load && !adv) |=> $stable(k_q)); // R10
endmodule

// File: rtl/sbs_mem.sv
module sbs_mem #(
  parameter int AW     = 8,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    we,
  input  logic [LANES-1:0]        wmask,
  input  logic [AW-1:0]           waddr,
  input  logic [LANES*LANE_W-1:0] wdata,
  input  logic [AW-1:0]           raddr,
  output logic [LANES*LANE_W-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] lane_q [DEPTH];
    always_ff @(posedge clk) begin
      if (we && wmask[g]) lane_q[waddr] <= wdata[g*LANE_W +: LANE_W];
    end
    assign rdata[g*LANE_W +: LANE_W] = lane_q[raddr];
  end
endmodule

// File: rtl/sburst_sram.sv
module sburst_sram
  import sbs_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  localparam int BUS_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              cpu_stb_n,
  input  logic              ctl_stb_n,
  input  logic              adv_n,
  input  logic              cs1_n,
  input  logic              cs2,
  input  logic              cs3_n,
  input  logic              gwe_n,
  input  logic              bwe_n,
  input  logic [LANES-1:0]  lane_sel_n,
  input  logic              oe_n,
  input  logic              lin_mode,
  input  logic              pdown,
  input  logic [BUS_W-1:0]  din,
  output logic [BUS_W-1:0]  dout,
  output logic              drv_en
);
  op_e               op;
  logic              sel, cpu_go, wr_req, load, step, asleep;
  logic              wr_now, rd_now, desel_now;
  logic [LANES-1:0]  wmask;
  logic [ADDR_W-1:0] cont_addr, acc_addr, rd_addr_q;
  logic              active_q, rd_stage_q, vld_q;
  logic [BUS_W-1:0]  rdata, dout_q;

  // Decode of the sampled control inputs.
  assign sel    = !cs1_n && cs2 && !cs3_n;
  assign cpu_go = !cpu_stb_n && !cs1_n;
  assign wmask  = !gwe_n ? '1 : (!bwe_n ? ~lane_sel_n : '0);
  assign wr_req = |wmask;

  always_comb begin
    op       = OP_IDLE;
    load     = 1'b0;
    step     = 1'b0;
    acc_addr = cont_addr;
    if (asleep) begin
      op = OP_IDLE;
    end else if (cpu_go) begin
      if (sel) begin
        op       = OP_READ;
        load     = 1'b1;
        acc_addr = addr;
      end else begin
        op = OP_DESEL;
      end
    end else if (!ctl_stb_n) begin
      if (sel) begin
        op       = wr_req ? OP_WRITE : OP_READ;
        load     = 1'b1;
        acc_addr = addr;
      end else begin
        op = OP_DESEL;
      end
    end else if (active_q) begin
      step = 1'b1;
      op   = wr_req ? OP_WRITE : OP_READ;
    end
  end

  assign wr_now    = (op == OP_WRITE);
  assign rd_now    = (op == OP_READ);
  assign desel_now = (op == OP_DESEL);

  sbs_sleep_sync u_sleep (
    .clk    (clk),
    .rst_n  (rst_n),
    .pdown  (pdown),
    .asleep (asleep)
  );

  sbs_burst_ctr #(.AW(ADDR_W)) u_burst (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load),
    .step      (step),
    .adv       (!adv_n),
    .lin       (lin_mode),
    .load_addr (addr),
    .cont_addr (cont_addr)
  );

  sbs_mem #(.AW(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_mem (
    .clk   (clk),
    .we    (wr_now),
    .wmask (wmask),
    .waddr (acc_addr),
    .wdata (din),
    .raddr (rd_addr_q),
    .rdata (rdata)
  );

  // Access state and read pipeline.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q   <= 1'b0;
      rd_stage_q <= 1'b0;
      vld_q      <= 1'b0;
      rd_addr_q  <= '0;
      dout_q     <= '0;
    end else begin
      if (asleep)         active_q <= 1'b0;
      else if (load)      active_q <= 1'b1;
      else if (desel_now) active_q <= 1'b0;
      rd_stage_q <= rd_now;
      rd_addr_q  <= acc_addr;
      vld_q      <= rd_stage_q && !desel_now && !wr_now && !asleep;
      if (rd_stage_q) dout_q <= rdata;
    end
  end

  assign dout   = dout_q;
  assign drv_en = vld_q && !oe_n && !asleep;

  AST_DESEL_TRISTATE: assert property (@(posedge clk) disable iff (!rst_n)
    desel_now |=> !drv_en); // R1
  AST_CS1_GATES_CPU: assert property (@(posedge clk) disable iff (!rst_n)
    (cs1_n && ctl_stb_n && !active_q) |=> !active_q); // R2
  AST_CPU_START_READS: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_go && sel && !asleep) |-> !wr_now); // R3
  AST_FIRST_CYCLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active_q) |-> !drv_en); // R7
  AST_WRITE_TRISTATE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_now |=> !drv_en); // R9
  AST_SLEEP_NO_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    asleep |=> !rd_stage_q && !active_q); // R12
endmodule

// File: tb/sim_sburst_sram.sv
`timescale 1ns/1ps
module sim_sburst_sram;
  localparam int AW = 6;
  localparam int NW = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic          cpu_n = 1'b1, ctl_n = 1'b1, adv_n = 1'b1;
  logic          cs1_n = 1'b0, cs2 = 1'b1, cs3_n = 1'b0;
  logic          gw_n = 1'b1, bw_n = 1'b1;
  logic [3:0]    bsel_n = 4'hF;
  logic          oe_n = 1'b0, lin = 1'b0, pdown = 1'b0;
  logic [35:0]   din = '0;
  logic [35:0]   dout;
  logic          drv_en;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  sburst_sram #(.ADDR_W(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .addr(addr), .cpu_stb_n(cpu_n), .ctl_stb_n(ctl_n),
    .adv_n(adv_n), .cs1_n(cs1_n), .cs2(cs2), .cs3_n(cs3_n), .gwe_n(gw_n),
    .bwe_n(bw_n), .lane_sel_n(bsel_n), .oe_n(oe_n), .lin_mode(lin),
    .pdown(pdown), .din(din), .dout(dout), .drv_en(drv_en)
  );

  // Shadow model state.
  logic [35:0]   m_mem [NW];
  logic          m_act = 0, m_rs = 0, m_vld = 0, m_s1 = 0, m_s2 = 0;
  logic [AW-1:0] m_ra = '0;
  logic [AW-3:0] m_base = '0;
  logic [1:0]    m_start = '0, m_k = '0;
  logic [35:0]   m_q = '0;

  function automatic logic [35:0] pat(input int a);
    logic [31:0] w = 32'(a) * 32'h0101_0101;
    return {a[3:0] ^ 4'h9, w ^ 32'hA5C3_0F69};
  endfunction

  function automatic logic [1:0] order(input logic [1:0] s, input logic [1:0] k, input logic l);
    int v;
    if (l) v = (int'(s) + int'(k)) % 4;
    else   v = int'({s[1] != k[1], s[0] != k[0]});
    return 2'(v);
  endfunction

  function automatic logic [35:0] merge(input logic [35:0] old, input logic [35:0] nw,
                                        input logic [3:0] m);
    logic [35:0] r = old;
    for (int g = 0; g < 4; g++) if (m[g]) r[g*9 +: 9] = nw[g*9 +: 9];
    return r;
  endfunction

  task automatic chk(input string tag, input logic [35:0] act, input logic [35:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_edge();
    logic sel, cpu, wrin, desel, do_rd, do_wr, nv;
    logic [3:0] mask;
    logic [AW-1:0] a;
    sel  = !cs1_n && cs2 && !cs3_n;
    cpu  = !cpu_n && !cs1_n;
    mask = !gw_n ? 4'hF : (!bw_n ? ~bsel_n : 4'h0);
    wrin = (mask != 4'h0);
    desel = 0; do_rd = 0; do_wr = 0; a = m_ra;
    if (m_s2) begin
      m_act = 0; m_rs = 0; m_vld = 0;
    end else begin
      if (cpu || !ctl_n) begin
        if (sel) begin
          m_base = addr[AW-1:2]; m_start = addr[1:0]; m_k = 0; m_act = 1;
          a = addr;
          if (!cpu && wrin) do_wr = 1; else do_rd = 1;
        end else desel = 1;
      end else if (m_act) begin
        if (!adv_n) m_k = m_k + 2'd1;
        a = {m_base, order(m_start, m_k, lin)};
        if (wrin) do_wr = 1; else do_rd = 1;
      end
      nv = m_rs && !desel && !do_wr;
      if (nv) m_q = m_mem[m_ra];
      m_vld = nv;
      if (do_wr) m_mem[a] = merge(m_mem[a], din, mask);
      m_rs = do_rd;
      m_ra = a;
      if (desel) m_act = 0;
    end
    m_s2 = m_s1;
    m_s1 = pdown;
  endtask

  task automatic step(input string tag);
    logic ed;
    @(posedge clk);
    model_edge();
    #1;
    ed = m_vld && !oe_n && !m_s2;
    chk(tag, {35'd0, drv_en}, {35'd0, ed});
    if (ed) chk(tag, dout, m_q);
  endtask

  task automatic idle();
    cpu_n = 1; ctl_n = 1; adv_n = 1; gw_n = 1; bw_n = 1; bsel_n = 4'hF;
    cs1_n = 0; cs2 = 1; cs3_n = 0;
  endtask

  task automatic deselect();
    idle(); ctl_n = 0; cs2 = 0; step("R1"); idle();
  endtask

  task automatic ctl_rd(input int a);
    idle(); ctl_n = 0; addr = AW'(a);
  endtask

  // Four-beat burst opened by the processor strobe; returns observed words.
  task automatic burst4(input int a, input logic l, output logic [35:0] obs [4]);
    lin = l; idle(); cpu_n = 0; addr = AW'(a); step("R10");
    for (int i = 0; i < 4; i++) begin
      idle(); adv_n = (i == 3); step(l ? "R11" : "R10");
      obs[i] = dout;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog all actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [35:0] obs [4];
    logic [35:0] d;
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset", {35'd0, drv_en}, 36'd0);
    @(negedge clk); rst_n = 1;
    #1;

    // Fill the array through the controller strobe, global write.
    for (int a = 0; a < NW; a++) begin
      idle(); ctl_n = 0; gw_n = 0; addr = AW'(a); din = pat(a); step("R4");
    end
    deselect();

    // R7 latency and back-to-back reads.
    ctl_rd(5); step("R7");
    chk("R7 first cycle", {35'd0, drv_en}, 36'd0);
    ctl_rd(6); step("R7");
    chk("R7 word5", dout, pat(5));
    ctl_rd(7); step("R7");
    chk("R7 word6", dout, pat(6));
    idle(); step("R7");
    chk("R7 word7", dout, pat(7));
    chk("R7 driven", {35'd0, drv_en}, 36'd1);
    // R8 asynchronous output enable.
    oe_n = 1; #1;
    chk("R8 oe high", {35'd0, drv_en}, 36'd0);
    oe_n = 0; #1;
    chk("R8 oe low", {35'd0, drv_en}, 36'd1);
    deselect();

    // R5 global write overrides lane selects.
    d = 36'h9_1234_5678;
    idle(); ctl_n = 0; addr = 10; gw_n = 0; bw_n = 0; bsel_n = 4'b1110; din = d; step("R5");
    ctl_rd(10); step("R5"); idle(); step("R5");
    chk("R5 all lanes", dout, d);
    // R6 lane write, lanes 1 and 3 only.
    idle(); ctl_n = 0; addr = 11; bw_n = 0; bsel_n = 4'b0101; din = d; step("R6");
    ctl_rd(11); step("R6"); idle(); step("R6");
    chk("R6 lanes 1,3", dout, {d[35:27], pat(11)[26:18], d[17:9], pat(11)[8:0]});
    // R6 byte enable high: read, no write.
    idle(); ctl_n = 0; addr = 12; bsel_n = 4'h0; din = ~pat(12); step("R6");
    ctl_rd(12); step("R6"); idle(); step("R6");
    chk("R6 bwe off keeps word", dout, pat(12));
    deselect();

    // R3 processor strobe ignores write inputs, write at continuation.
    idle(); cpu_n = 0; addr = 9; gw_n = 0; din = 36'h1_1111_1111; step("R3");
    idle(); adv_n = 0; gw_n = 0; din = 36'h2_2222_2222; step("R3");
    chk("R3 write tri", {35'd0, drv_en}, 36'd0);
    deselect();
    ctl_rd(9); step("R3"); ctl_rd(8); step("R3");
    chk("R3 start not written", dout, pat(9));
    idle(); step("R3");
    chk("R3 continuation written", dout, 36'h2_2222_2222);
    deselect();

    // R10 interleaved from start 1, then a suspend beat.
    burst4(17, 1'b0, obs);
    chk("R10 beat0", obs[0], pat(17));
    chk("R10 beat1", obs[1], pat(16));
    chk("R10 beat2", obs[2], pat(19));
    chk("R10 beat3", obs[3], pat(18));
    idle(); step("R10");
    chk("R10 suspend", dout, pat(18));
    deselect();
    // R11 linear from start 1.
    burst4(33, 1'b1, obs);
    chk("R11 beat0", obs[0], pat(33));
    chk("R11 beat1", obs[1], pat(34));
    chk("R11 beat2", obs[2], pat(35));
    chk("R11 beat3", obs[3], pat(32));
    lin = 0;
    deselect();

    // R2 processor strobe with cs1_n high.
    idle(); cs1_n = 1; cpu_n = 0; addr = 40; step("R2");
    idle(); step("R2");
    chk("R2 no start", {35'd0, drv_en}, 36'd0);
    ctl_rd(20); step("R2");
    idle(); cs1_n = 1; cpu_n = 0; addr = 40; step("R2");
    chk("R2 burst kept", dout, pat(20));
    chk("R2 burst driven", {35'd0, drv_en}, 36'd1);
    idle(); step("R2");
    chk("R2 still word20", dout, pat(20));
    deselect();

    // R1 deselect drops in-flight read.
    ctl_rd(21); step("R1");
    idle(); ctl_n = 0; cs3_n = 1; step("R1");
    chk("R1 desel tri", {35'd0, drv_en}, 36'd0);
    // R9 write right after a read.
    ctl_rd(22); step("R9");
    idle(); ctl_n = 0; addr = 23; gw_n = 0; din = pat(23); step("R9");
    chk("R9 write tri", {35'd0, drv_en}, 36'd0);
    deselect();

    // R12 sleep.
    pdown = 1;
    for (int i = 0; i < 3; i++) begin idle(); step("R12"); end
    idle(); ctl_n = 0; addr = 24; gw_n = 0; din = 36'hF_0000_000F; step("R12");
    ctl_rd(24); step("R12"); idle(); step("R12");
    chk("R12 asleep tri", {35'd0, drv_en}, 36'd0);
    pdown = 0;
    for (int i = 0; i < 3; i++) begin idle(); step("R12"); end
    ctl_rd(24); step("R12"); idle(); step("R12");
    chk("R12 retained", dout, pat(24));

    // Constrained random traffic against the shadow model.
    for (int n = 0; n < 4000; n++) begin
      int r;
      r = int'($urandom % 6);
      cpu_n  = (r != 0);
      ctl_n  = (r != 1);
      addr   = AW'($urandom);
      cs1_n  = ($urandom % 8 == 0);
      cs2    = ($urandom % 8 != 0);
      cs3_n  = ($urandom % 8 == 0);
      gw_n   = ($urandom % 4 != 0);
      bw_n   = ($urandom % 2 != 0);
      bsel_n = 4'($urandom);
      adv_n  = ($urandom % 2 != 0);
      oe_n   = ($urandom % 5 == 0);
      din    = {4'($urandom), 32'($urandom)};
      if (n % 500 == 0) lin = ~lin;
      if ($urandom % 150 == 0) pdown = ~pdown;
      step("R7 random");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule